// File: doc/BRIEF.md
# Masked Control Register File

This block holds a processor's 64-bit internal control registers behind a single indexed access port. Each cycle one request is accepted: a read or a write of the register selected by a 5-bit index. A write stores only the bits that are defined for that register. Some registers clear on any write. One register returns a live cycle count in its lower half. Each index has its own access rule, and a request that breaks it is reported on an error flag.

A read is answered on `rsp_rdata` one cycle after it is accepted. The value then stays put until the next read. `rsp_err` is a registered flag. It is high for exactly the cycle after an illegal request.

Index map, as used by software and the bench:

- Indices 0 to 7 are scratch registers that keep all 64 bits.
- 8 is the trap base.
- 9 is the exception return address.
- 10 and 11 are the asynchronous trap request and enable registers.
- 12 is the priority level.
- 13 and 14 are the instruction and data mode registers.
- 15 is the alternate mode register, which is write-only.
- 16 is the instruction control register.
- 17 and 18 are the cache mode and miss-queue mode registers.
- 19 is the cache test control register.
- 20 and 21 are the instruction and data address-space identifiers.
- 22 and 23 are the instruction and data page-table bases.
- 24 and 25 are the exception summary and exception mask registers.
- 26 is the cycle register.
- 27 is the machine control register.
- 28 is the interrupt identifier, which is read-only.
- 29 is the flush command, which is write-only.
- 30 and 31 are undefined.

Top module: `ctl_reg_file`

## Requirements
- R1: After reset every register reads zero, with three exceptions. Index 27 reads 0x6, index 8 reads parameter TRAP_BASE_RST, and the scratch index CORE_ID_SLOT reads parameter CORE_ID. After reset `rsp_rdata` and `rsp_err` are 0.
- R2: Scratch indices 0 to 7, and also indices 8 and 27, store and return the full 64-bit written value.
- R3: A write to index 9 stores the data with bit 1 forced to zero. All other bits are kept.
- R4: Writes keep only these bits: indices 10 and 11 keep bits 3:0, index 12 keeps bits 4:0, and indices 13, 14 and 15 keep bits 4:3 (mask 0x18).
- R5: Writes are masked as follows:
  - index 16 with 0xFF_FFFF_0300;
  - indices 17 and 18 with 0x3F;
  - index 19 with 0x1FFB;
  - index 20 with 0x7F0;
  - index 21 keeps bits 63:57;
  - indices 22 and 23 keep bits 63:30.
- R6: Any write to index 24 or index 25, whatever the data, leaves the register at zero.
- R7: A write to index 26 stores all 64 bits. A read of index 26 returns the stored bits 63:32 above the low 32 bits of a cycle counter. That counter is zero in the first clock edge after reset is released and advances by one at every edge after that. The value returned is the count at the edge where the read is accepted.
- R8: A read of write-only index 15 or 29 is illegal.
- R9: A write to read-only index 28 is illegal. Index 28 keeps reading zero.
- R10: Any read or write of index 30 or 31 is illegal.
- R11: An illegal request raises `rsp_err` for exactly the following cycle, changes no register, and for a read returns zero on `rsp_rdata`. A legal request leaves `rsp_err` low in the following cycle.
- R12: A read accepted at an edge is visible on `rsp_rdata` after that edge. `rsp_rdata` holds its value in every cycle that follows a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Registered read data |
| rsp_err | output | 1 | One-cycle illegal-access flag |

## Verification
Two things can happen in the same cycle. A write to the cycle register can land in the same cycle in which the free-running counter advances. A read of the cycle register can also be accepted in the cycle right after such a write. The bench sweeps the whole index space several times with different data patterns, and every sweep includes those write-then-read pairs. Each cycle read is judged in two parts: the upper half must equal the written upper half, and the lower half must equal the bench's own count of clock edges since reset. Because of this, neither the written lower half nor a stale counter value can pass.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  localparam int IX_SCR_LAST  = 7;
  localparam int IX_TRAP_BASE = 8;
  localparam int IX_EXC_RET   = 9;
  localparam int IX_AST_REQ   = 10;
  localparam int IX_AST_EN    = 11;
  localparam int IX_PRIO      = 12;
  localparam int IX_IMODE     = 13;
  localparam int IX_DMODE     = 14;
  localparam int IX_ALTMODE   = 15;
  localparam int IX_ICTL      = 16;
  localparam int IX_CMODE     = 17;
  localparam int IX_MQMODE    = 18;
  localparam int IX_CTEST     = 19;
  localparam int IX_IASID     = 20;
  localparam int IX_DASID     = 21;
  localparam int IX_IPTB      = 22;
  localparam int IX_DPTB      = 23;
  localparam int IX_EXSUM     = 24;
  localparam int IX_EXMSK     = 25;
  localparam int IX_CYCLE     = 26;
  localparam int IX_MCTL      = 27;
  localparam int IX_INTID     = 28;
  localparam int IX_FLUSH     = 29;
  localparam int IX_LAST_DEF  = 29;

  localparam logic [DATA_W-1:0] MCTL_RST = 64'h6;

  typedef enum logic [1:0] {
    WK_MASKED = 2'd0,
    WK_CLEAR  = 2'd1,
    WK_CYCLE  = 2'd2
  } wr_kind_e;

  typedef struct packed {
    logic              rd_ok;
    logic              wr_ok;
    wr_kind_e          kind;
    logic [DATA_W-1:0] mask;
  } slot_attr_t;
endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output slot_attr_t       attr
);
  localparam logic [DATA_W-1:0] ALL1 = '1;

  always_comb begin
    attr.rd_ok = 1'b1;
    attr.wr_ok = 1'b1;
    attr.kind  = WK_MASKED;
    attr.mask  = ALL1;
    if (int'(idx) <= IX_SCR_LAST) begin
      attr.mask = ALL1;
    end else begin
      case (int'(idx))
        IX_TRAP_BASE, IX_MCTL: attr.mask = ALL1;
        IX_EXC_RET:            attr.mask = ~64'h2;
        IX_AST_REQ, IX_AST_EN: attr.mask = 64'hF;
        IX_PRIO:               attr.mask = 64'h1F;
        IX_IMODE, IX_DMODE:    attr.mask = 64'h18;
        IX_ALTMODE: begin
          attr.mask  = 64'h18;
          attr.rd_ok = 1'b0;
        end
        IX_ICTL:               attr.mask = 64'hFF_FFFF_0300;
        IX_CMODE, IX_MQMODE:   attr.mask = 64'h3F;
        IX_CTEST:              attr.mask = 64'h1FFB;
        IX_IASID:              attr.mask = 64'h7F0;
        IX_DASID:              attr.mask = 64'hFE00_0000_0000_0000;
        IX_IPTB, IX_DPTB:      attr.mask = 64'hFFFF_FFFF_C000_0000;
        IX_EXSUM, IX_EXMSK: begin
          attr.kind = WK_CLEAR;
          attr.mask = '0;
        end
        IX_CYCLE:              attr.kind = WK_CYCLE;
        IX_INTID: begin
          attr.wr_ok = 1'b0;
          attr.mask  = '0;
        end
        IX_FLUSH:              attr.rd_ok = 1'b0;
        default: begin
          attr.rd_ok = 1'b0;
          attr.wr_ok = 1'b0;
          attr.mask  = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctl_cycle_ctr.sv
module ctl_cycle_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
  import ctl_reg_pkg::*;
#(
  parameter int                IDX_W         = 5,
  parameter logic [DATA_W-1:0] TRAP_BASE_RST = '0,
  parameter logic [DATA_W-1:0] CORE_ID       = '0,
  parameter int                CORE_ID_SLOT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wval,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword
);
  localparam int SLOTS = 1 << IDX_W;

  logic [DATA_W-1:0] mem [SLOTS];

  function automatic logic [DATA_W-1:0] reset_word(input int ix);
    if (ix == IX_MCTL)           return MCTL_RST;
    else if (ix == IX_TRAP_BASE) return TRAP_BASE_RST;
    else if (ix == CORE_ID_SLOT) return CORE_ID;
    else                         return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= reset_word(i);
    end else if (we) begin
      mem[widx] <= wval;
    end
  end

  assign rword = mem[ridx];
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import ctl_reg_pkg::*;
#(
  parameter int                IDX_W         = 5,
  parameter logic [DATA_W-1:0] TRAP_BASE_RST = 64'h0000_0000_0001_0000,
  parameter logic [DATA_W-1:0] CORE_ID       = 64'h0,
  parameter int                CORE_ID_SLOT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err
);
  slot_attr_t        attr;
  logic              legal;
  logic              we;
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] rd_word;
  logic [HALF_W-1:0] live_cnt;

  ctl_reg_decode #(.IDX_W(IDX_W)) dec_i (
    .idx  (req_idx),
    .attr (attr)
  );

  ctl_cycle_ctr #(.CNT_W(HALF_W)) ctr_i (
    .clk   (clk),
    .rst   (rst),
    .count (live_cnt)
  );

  ctl_reg_store #(
    .IDX_W         (IDX_W),
    .TRAP_BASE_RST (TRAP_BASE_RST),
    .CORE_ID       (CORE_ID),
    .CORE_ID_SLOT  (CORE_ID_SLOT)
  ) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .widx  (req_idx),
    .wval  (wval),
    .ridx  (req_idx),
    .rword (stored)
  );

  always_comb begin
    legal = req_write ? attr.wr_ok : attr.rd_ok;
    we    = req_valid & req_write & legal;
    case (attr.kind)
      WK_CLEAR: wval = '0;
      WK_CYCLE: wval = req_wdata;
      default:  wval = req_wdata & attr.mask;
    endcase
    if (attr.kind == WK_CYCLE) rd_word = {stored[DATA_W-1:HALF_W], live_cnt};
    else                       rd_word = stored;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_err <= req_valid & ~legal;
      if (req_valid & ~req_write) rsp_rdata <= legal ? rd_word : '0;
    end
  end
endmodule

// File: rtl/ctl_reg_file_chk.sv
module ctl_reg_file_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [IDX_W-1:0] req_idx,
  input logic [63:0]      rsp_rdata,
  input logic             rsp_err
);
  logic rd_req;
  logic wr_req;
  assign rd_req = req_valid & ~req_write;
  assign wr_req = req_valid & req_write;

  p_scratch_ok_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && int'(req_idx) < 8 |=> !rsp_err);

  p_prio_width_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req && int'(req_idx) == 12 |=> rsp_rdata[63:5] == '0);

  p_exc_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req && (int'(req_idx) == 24 || int'(req_idx) == 25) |=> rsp_rdata == '0);

  p_wo_read_err_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req && (int'(req_idx) == 15 || int'(req_idx) == 29) |=> rsp_err);

  p_ro_write_err_r9: assert property (@(posedge clk) disable iff (rst)
    wr_req && int'(req_idx) == 28 |=> rsp_err);

  p_undef_err_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && int'(req_idx) >= 30 |=> rsp_err);

  p_bad_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req && int'(req_idx) >= 30 |=> rsp_rdata == '0);

  p_err_drop_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_err);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rsp_rdata));
endmodule

bind ctl_reg_file ctl_reg_file_chk #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_idx   (req_idx),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/ctl_reg_file_tb_top.sv
`timescale 1ns/1ps
module ctl_reg_file_tb_top;
  localparam logic [63:0] TB_TRAP = 64'h0000_0000_0001_0000;
  localparam logic [63:0] TB_CORE = 64'h0000_0000_0000_0003;
  localparam int          TB_SLOT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic        rsp_err;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] ecount = '0;
  logic [63:0] model [32];

  always #10 clk = ~clk;

  always @(posedge clk) ecount <= rst ? 32'd0 : ecount + 32'd1;

  ctl_reg_file #(
    .IDX_W(5), .TRAP_BASE_RST(TB_TRAP), .CORE_ID(TB_CORE), .CORE_ID_SLOT(TB_SLOT)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic string req_of(input int ix);
    if (ix <= 7) return "R2";
    case (ix)
      8, 27: return "R1";
      9: return "R3";
      10, 11, 12, 13, 14: return "R4";
      16, 17, 18, 19, 20, 21, 22, 23: return "R5";
      24, 25: return "R6";
      26: return "R7";
      15, 29: return "R8";
      28: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [63:0] keep_bits(input int ix);
    case (ix)
      9: return ~(64'd1 << 1);
      10, 11: return (64'd1 << 4) - 1;
      12: return (64'd1 << 5) - 1;
      13, 14, 15: return 64'd3 << 3;
      16: return (((64'd1 << 24) - 1) << 16) | (64'd3 << 8);
      17, 18: return (64'd1 << 6) - 1;
      19: return ((64'd1 << 13) - 1) & ~(64'd1 << 2);
      20: return ((64'd1 << 7) - 1) << 4;
      21: return ((64'd1 << 7) - 1) << 57;
      22, 23: return ~((64'd1 << 30) - 1);
      24, 25: return 64'd0;
      default: return ~64'd0;
    endcase
  endfunction

  function automatic bit rd_legal(input int ix);
    return !(ix == 15 || ix == 29 || ix >= 30);
  endfunction

  function automatic bit wr_legal(input int ix);
    return !(ix == 28 || ix >= 30);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s flag actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_op(input bit w, input int ix, input logic [63:0] d);
    req_valid = 1'b1;
    req_write = w;
    req_idx   = ix[4:0];
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic write_chk(input int ix, input logic [63:0] d);
    bit bad;
    bad = !wr_legal(ix);
    do_op(1'b1, ix, d);
    check1(bad ? "R11" : req_of(ix), rsp_err, bad);
    if (!bad) model[ix] = d & keep_bits(ix);
  endtask

  task automatic read_chk(input int ix);
    logic [63:0] exp;
    bit bad;
    bad = !rd_legal(ix);
    if (bad) exp = '0;
    else if (ix == 26) exp = {model[26][63:32], ecount};
    else exp = model[ix];
    do_op(1'b0, ix, 64'hDEAD_BEEF_DEAD_BEEF);
    check64(req_of(ix), rsp_rdata, exp);
    check1(bad ? "R11" : req_of(ix), rsp_err, bad);
  endtask

  initial begin
    logic [63:0] pats [4];
    logic [63:0] held;
    pats[0] = ~64'd0;
    pats[1] = 64'hA5A5_5A5A_F00F_0FF0;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'd0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[8]  = TB_TRAP;
    model[27] = 64'h6;
    model[TB_SLOT] = TB_CORE;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check64("R1", rsp_rdata, 64'd0);
    check1("R1", rsp_err, 1'b0);
    for (int i = 0; i < 32; i++) read_chk(i);

    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 32; i++) write_chk(i, pats[p] ^ (64'(i) << 40));
      write_chk(26, pats[p]);
      read_chk(26);
      for (int i = 0; i < 32; i++) read_chk(i);
    end

    // R11: error flag lasts one cycle and an undefined write changes nothing
    write_chk(30, ~64'd0);
    @(negedge clk);
    check1("R11", rsp_err, 1'b0);
    for (int i = 0; i < 8; i++) read_chk(i);
    write_chk(28, ~64'd0);
    read_chk(28);

    // R12: read data holds across writes and idle cycles
    write_chk(3, 64'h1111_2222_3333_4444);
    read_chk(3);
    held = rsp_rdata;
    write_chk(3, 64'h5555_6666_7777_8888);
    check64("R12", rsp_rdata, held);
    repeat (4) @(negedge clk);
    check64("R12", rsp_rdata, held);
    read_chk(3);

    // R7: spaced cycle reads
    read_chk(26);
    repeat (7) @(negedge clk);
    read_chk(26);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule